// File: doc/BRIEF.md
# Sequential Radix-2 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits. It works one multiplier bit per clock cycle. A single working register holds a running partial sum in its upper half and the multiplier in its lower half. A guard bit to the right of that register keeps the bit that was last shifted out. In every step the block reads the multiplier-register LSB together with the guard bit. From that pair it either adds the multiplicand to the upper half, subtracts it, or leaves the upper half alone. It then shifts the whole register one place right arithmetically.

The handshake is minimal. A `start` pulse while the block is idle captures both operands. `busy` stays high for exactly `WIDTH` cycles, and `done` then pulses for one cycle, with the result already on `product`. The result remains on `product` until the next accepted `start`. Because the partial sum is formed one bit wider than the operands, the most negative multiplicand cannot overflow before the shift.

Top module: `seq_booth_multiplier`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `busy` and `done` are 0 and `product` is all zeros.
- R2: When `start` is high at a rising edge while `busy` is 0, `op_a` is taken as the multiplicand and `op_b` as the multiplier, and `busy` is 1 from the next cycle.
- R3: `busy` stays high for exactly `WIDTH` cycles. `done` is high for exactly one cycle, the cycle right after the last busy cycle. `done` and `busy` are never high together.
- R4: When `done` is high, `product` equals the signed product `op_a * op_b` as a `2*WIDTH`-bit two's-complement value. This holds for every operand pair, including those where either operand is -2^(WIDTH-1).
- R5: Each step reads the pair {multiplier-register LSB, guard bit}, where the guard bit is 0 after a start. Pair 10 subtracts the multiplicand from the upper half, pair 01 adds it, and pairs 00 and 11 do no arithmetic. The whole register then shifts right by one with its MSB replicated, and the bit shifted out becomes the new guard bit.
- R6: A `start` pulse while `busy` is 1 is ignored: neither the running operation, its result nor its timing changes.
- R7: While `busy` is 0 and no `start` is accepted, `product` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication (taken only when idle) |
| op_a | input | WIDTH | Signed multiplicand |
| op_b | input | WIDTH | Signed multiplier |
| busy | output | 1 | High while the iteration steps run |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Signed result, held until the next accepted start |

## Verification
A 4-bit instance is driven with all 256 operand pairs. This covers every bit-pair sequence the recoder can meet, including the -8 corner that needs the widened sum. The 32-bit instance runs a table of signed cases. These include two negatives, mixed signs, the most negative value on either side, and all-ones multipliers, which separate a wrong add/subtract choice from a wrong shift sign. Random 32-bit pairs are then checked against the language's own multiply. Directed cases cover a multiplier of zero (no arithmetic at any step), a multiplier of one (a single subtract, then an add), start pulses during a run, holding after completion, and a reset in the middle of an operation.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Arithmetic chosen for one step
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_ADD  = 2'b01,
    STEP_SUB  = 2'b10
  } step_op_e;

  // Map {register LSB, guard bit} to a step operation
  function automatic step_op_e recode_pair(input logic [1:0] pair);
    case (pair)
      2'b10:   return STEP_SUB;   // a run of ones begins
      2'b01:   return STEP_ADD;   // a run of ones has ended
      default: return STEP_NONE;  // inside a run of zeros or of ones
    endcase
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mul_pkg::*;
(
  input  logic [1:0] pair,
  output step_op_e   op
);

  always_comb op = recode_pair(pair);

endmodule

// File: rtl/booth_step_unit.sv
module booth_step_unit
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] mplr,
  input  logic [WIDTH-1:0] mcand,
  input  step_op_e         op,
  output logic [WIDTH-1:0] acc_nx,
  output logic [WIDTH-1:0] mplr_nx,
  output logic             guard_nx
);

  localparam int SUM_W = WIDTH + 1;

  // Sign-extended add or subtract, one bit wider than the operands
  function automatic logic [SUM_W-1:0] wide_sum(input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] m,
                                                input step_op_e         o);
    logic [SUM_W-1:0] ax;
    logic [SUM_W-1:0] mx;
    ax = {a[WIDTH-1], a};
    mx = {m[WIDTH-1], m};
    case (o)
      STEP_ADD: return ax + mx;
      STEP_SUB: return ax - mx;
      default:  return ax;
    endcase
  endfunction

  logic [SUM_W-1:0] sum_w;

  always_comb begin
    sum_w    = wide_sum(acc, mcand, op);
    // shifting {sum, mplr} right by one: the wide sign becomes the new MSB
    acc_nx   = sum_w[SUM_W-1:1];
    mplr_nx  = {sum_w[0], mplr[WIDTH-1:1]};
    guard_nx = mplr[0];
  end

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] step_idx;
  logic             last_step;

  assign load      = start && !busy;
  assign step      = busy;
  assign last_step = busy && (step_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_idx <= '0;
    end else begin
      done <= last_step;
      if (load) begin
        busy     <= 1'b1;
        step_idx <= '0;
      end else if (busy) begin
        step_idx <= step_idx + 1'b1;
        if (last_step) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/seq_booth_multiplier.sv
module seq_booth_multiplier
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WIDTH-1:0]     op_a,
  input  logic [WIDTH-1:0]     op_b,
  output logic                 busy,
  output logic                 done,
  output logic [2*WIDTH-1:0]   product
);

  logic [WIDTH-1:0] acc_q, mplr_q, mcand_q;
  logic             guard_q;
  logic [WIDTH-1:0] acc_nx, mplr_nx;
  logic             guard_nx;
  logic             load_w, step_w;
  logic [1:0]       pair_w;
  step_op_e         op_w;

  booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load_w),
    .step  (step_w),
    .busy  (busy),
    .done  (done)
  );

  assign pair_w = {mplr_q[0], guard_q};

  booth_recoder u_recode (
    .pair (pair_w),
    .op   (op_w)
  );

  booth_step_unit #(.WIDTH(WIDTH)) u_step (
    .acc      (acc_q),
    .mplr     (mplr_q),
    .mcand    (mcand_q),
    .op       (op_w),
    .acc_nx   (acc_nx),
    .mplr_nx  (mplr_nx),
    .guard_nx (guard_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mplr_q  <= '0;
      mcand_q <= '0;
      guard_q <= 1'b0;
    end else if (load_w) begin
      acc_q   <= '0;
      mplr_q  <= op_b;
      mcand_q <= op_a;
      guard_q <= 1'b0;
    end else if (step_w) begin
      acc_q   <= acc_nx;
      mplr_q  <= mplr_nx;
      guard_q <= guard_nx;
    end
  end

  assign product = {acc_q, mplr_q};

endmodule

// File: rtl/booth_mul_checker.sv
module booth_mul_checker #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product,
  input logic [1:0]         pair
);

  localparam int LAT_W = $clog2(WIDTH + 1) + 1;

  logic [LAT_W-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_run <= '0;
    else if (busy)  busy_run <= busy_run + 1'b1;
    else            busy_run <= '0;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_run == LAT_W'(WIDTH)));

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_run_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < LAT_W'(WIDTH)));

  p_noop_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (pair == 2'b00 || pair == 2'b11))
      |=> ($signed(product) == ($signed($past(product)) >>> 1)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

endmodule

bind seq_booth_multiplier booth_mul_checker #(.WIDTH(WIDTH)) u_booth_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product),
  .pair    (pair_w)
);

// File: tb/test_seq_booth_multiplier.sv
module test_seq_booth_multiplier;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // 32-bit instance
  logic        start32 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        busy32, done32;
  logic [63:0] prod32;

  seq_booth_multiplier #(.WIDTH(32)) i_seq_booth_multiplier (
    .clk(clk), .rst_n(rst_n), .start(start32), .op_a(a32), .op_b(b32),
    .busy(busy32), .done(done32), .product(prod32));

  // 4-bit instance for the exhaustive sweep
  logic       start4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       busy4, done4;
  logic [7:0] prod4;

  seq_booth_multiplier #(.WIDTH(4)) i_seq_booth_multiplier_w4 (
    .clk(clk), .rst_n(rst_n), .start(start4), .op_a(a4), .op_b(b4),
    .busy(busy4), .done(done4), .product(prod4));

  int n_chk = 0;
  int n_fail = 0;

  localparam int NVEC = 8;
  localparam logic [31:0] T_A [NVEC] = '{32'hFFFF_FFFC, 32'd12, 32'hFFFF_FFFE, 32'd0,
                                         32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] T_B [NVEC] = '{32'hFFFF_FFF9, 32'd9, 32'd3, 32'hFFFF_FFFF,
                                         32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [63:0] T_P [NVEC] = '{64'd28, 64'd108, 64'hFFFF_FFFF_FFFF_FFFA, 64'd0,
                                         64'h4000_0000_0000_0000, 64'hC000_0000_8000_0000,
                                         64'h3FFF_FFFF_0000_0001, 64'd1};

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b,
                       output logic [63:0] res, output int lat);
    @(negedge clk);
    start32 = 1'b1; a32 = a; b32 = b;
    @(negedge clk);
    start32 = 1'b0;
    lat = 1;
    while (!done32 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = prod32;
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, output logic [7:0] res);
    @(negedge clk);
    start4 = 1'b1; a4 = a; b4 = b;
    @(negedge clk);
    start4 = 1'b0;
    while (!done4) @(negedge clk);
    res = prod4;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] res;
    logic [7:0]  res4;
    logic [63:0] held;
    int          lat;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy32 == 1'b0 && done32 == 1'b0, "R1 flags in reset", {busy32, done32}, 0);
    check(prod32 == 64'd0, "R1 product in reset", prod32, 0);
    rst_n = 1'b1;

    // R2 / R3: handshake timing on the first table entry
    @(negedge clk);
    start32 = 1'b1; a32 = T_A[0]; b32 = T_B[0];
    @(negedge clk);
    start32 = 1'b0;
    check(busy32 == 1'b1, "R2 busy after start", busy32, 1);
    lat = 1;
    while (!done32 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 33, "R3 done latency", lat, 33);
    check(busy32 == 1'b0, "R3 busy low with done", busy32, 0);
    check(prod32 == T_P[0], "R4 -4 x -7", prod32, T_P[0]);
    @(negedge clk);
    check(done32 == 1'b0, "R3 done single cycle", done32, 0);

    // R4: table of signed corner vectors
    for (int i = 0; i < NVEC; i++) begin
      run32(T_A[i], T_B[i], res, lat);
      check(res == T_P[i], "R4 table vector", res, T_P[i]);
      check(lat == 33, "R3 latency per vector", lat, 33);
    end

    // R5: multiplier zero (no arithmetic at all) and one (subtract then add)
    run32(32'h1234_5678, 32'd0, res, lat);
    check(res == 64'd0, "R5 multiplier zero", res, 0);
    run32(32'h8765_4321, 32'd1, res, lat);
    check(res == {{32{1'b1}}, 32'h8765_4321}, "R5 multiplier one", res,
          {{32{1'b1}}, 32'h8765_4321});
    run32(32'd3, 32'h5555_5555, res, lat);
    check(res == 64'(64'sd3 * 64'sh5555_5555), "R5 alternating multiplier", res,
          64'(64'sd3 * 64'sh5555_5555));

    // R7: product held while idle
    held = prod32;
    repeat (10) @(negedge clk);
    check(prod32 == held && !done32 && !busy32, "R7 idle hold", prod32, held);

    // R6: start pulses during a run are ignored
    @(negedge clk);
    start32 = 1'b1; a32 = 32'd5; b32 = 32'd7;
    @(negedge clk);
    start32 = 1'b0;
    lat = 1;
    repeat (3) begin @(negedge clk); lat++; end
    start32 = 1'b1; a32 = 32'd100; b32 = 32'd100;
    @(negedge clk);
    lat++;
    start32 = 1'b0;
    while (!done32 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(prod32 == 64'd35, "R6 result unchanged by busy start", prod32, 35);
    check(lat == 33, "R6 timing unchanged by busy start", lat, 33);

    // R4: random 32-bit pairs
    for (int i = 0; i < 200; i++) begin
      logic [31:0] ra, rb;
      logic [63:0] exp;
      ra = $urandom;
      rb = $urandom;
      exp = 64'($signed(ra)) * 64'($signed(rb));
      run32(ra, rb, res, lat);
      check(res == exp, "R4 random pair", res, exp);
    end

    // R4 / R5: exhaustive 4-bit sweep
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        logic [7:0] exp4;
        exp4 = 8'($signed(4'(ia)) * $signed(4'(ib)));
        run4(4'(ia), 4'(ib), res4);
        check(res4 == exp4, "R4 exhaustive 4-bit", {56'd0, res4}, {56'd0, exp4});
      end
    end

    // R1: reset in the middle of an operation
    @(negedge clk);
    start32 = 1'b1; a32 = 32'd9; b32 = 32'd9;
    @(negedge clk);
    start32 = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!busy32 && !done32 && prod32 == 64'd0, "R1 mid-run reset", prod32, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run32(32'hFFFF_FFF9, 32'd6, res, lat);
    check(res == 64'hFFFF_FFFF_FFFF_FFD6, "R4 after reset", res, 64'hFFFF_FFFF_FFFF_FFD6);

    finish_run();
  end

endmodule